// File: doc/BRIEF.md
# Receive FIFO with Hysteretic Auto-RTS

This block buffers received characters between a serial-to-parallel stage and a host. The receiver pushes each assembled byte with a one-cycle write strobe. The host pops bytes through a show-ahead read port: the oldest byte is always visible on the read data output, and a read strobe removes it. The buffer holds 64 bytes. It reports its fill level, empty, full and a sticky overflow flag.

The block drives an active-low request-to-send output from the fill level, using hysteresis. One 8-bit configuration byte holds two 4-bit thresholds, and each threshold is scaled by 4 characters. The low nibble is the stop threshold: once the level reaches it, the request is withdrawn. The high nibble is the restart threshold: the request returns only after host reads bring the level down to it. Even the highest stop threshold (60) leaves at least four free entries. This room absorbs a character that the far end had already started to send when the request was withdrawn.

Top module: `rx_fifo_autorts`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, `ovf` is 0 and `rts_n` is 0.
- R2: Bytes leave in the order they were written. `rd_data` shows the oldest stored byte while the buffer is not empty. A read while empty is ignored and leaves the level at 0.
- R3: A write while full, with no read in the same cycle, drops the byte, leaves the level at 64 and sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed.
- R4: A read and a write in the same cycle on a non-empty buffer leave the level unchanged. This holds when the buffer is full, and in that case `ovf` is not set.
- R5: The stop level is 4 times `trig_cfg[3:0]`. The restart level is 4 times `trig_cfg[7:4]`.
- R6: The request is withdrawn (`rts_n` goes to 1) one cycle after the registered level becomes greater than or equal to the stop level.
- R7: Once withdrawn, the request is re-granted (`rts_n` goes to 0) one cycle after the level falls to the restart level or below. It is not re-granted while the level stays above the restart level.
- R8: If the restart level is not below the stop level, the restart level used is the stop level minus 4, or 0 when the stop level is 0. The stop condition takes priority, so with a stop level of 0 the request stays withdrawn.
- R9: After the request is withdrawn at any stop level, one more write is accepted without loss, and the level rises by one.
- R10: While `rts_auto_en` is 0, `rts_n` is driven 0 (request asserted), whatever the level is.
- R11: `full` is 1 exactly when the level is 64, and `empty` is 1 exactly when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| trig_cfg | input | 8 | [3:0] stop threshold, [7:4] restart threshold, each in units of 4 characters |
| rts_auto_en | input | 1 | 1: RTS follows the level; 0: RTS held asserted |
| ovf_clr | input | 1 | Clears the overflow flag |
| level | output | 7 | Number of stored bytes, 0 to 64 |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is 64 |
| ovf | output | 1 | Sticky overflow flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench sweeps all 256 threshold pairs. For each pair it fills the buffer from empty to the stop level and writes one extra byte, then drains the buffer, comparing `rts_n` and the level after every single operation. A design that released the request one level too early or too late, or that withdrew it one byte late, fails at that exact level. So does a design that ignored the reversed-threshold rule, which would hold the request or let it oscillate. The pairs where the restart threshold is at or above the stop threshold, including a stop threshold of 0, are covered by the same sweep. Separate sequences write into a full buffer, read and write together while full, read while empty, and clear the overflow flag. A design that counted the dropped byte, lost the paired write, or let `level` wrap would show a wrong level or a wrong flag.

// File: rtl/rx_fifo_autorts.sv
module rx_fifo_autorts #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int STEP   = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [7:0]        trig_cfg,
  input  logic              rts_auto_en,
  input  logic              ovf_clr,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              rts_n
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          halted;

  logic rd_ok, wr_ok;
  assign empty = (cnt == '0);
  assign full  = (cnt == LW'(DEPTH));
  assign rd_ok = rd_en && !empty;
  assign wr_ok = wr_en && (!full || rd_ok);
  assign level = cnt;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
      if (wr_en && !wr_ok) ovf <= 1'b1;
      else if (ovf_clr)    ovf <= 1'b0;
    end
  end

  logic [LW-1:0] halt_lv, res_raw, res_lv;
  assign halt_lv = LW'(int'(trig_cfg[3:0]) * STEP);
  assign res_raw = LW'(int'(trig_cfg[7:4]) * STEP);
  assign res_lv  = (res_raw < halt_lv) ? res_raw :
                   (halt_lv >= LW'(STEP)) ? halt_lv - LW'(STEP) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                halted <= 1'b0;
    else if (cnt >= halt_lv)   halted <= 1'b1;
    else if (cnt <= res_lv)    halted <= 1'b0;
  end

  assign rts_n = rts_auto_en & halted;

  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && ovf));
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  p_pair_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !empty) |=> $stable(cnt));
  p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty);
  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= halt_lv) |=> halted);
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && cnt > res_lv && cnt < halt_lv) |=> halted);
  p_res_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_lv != '0) |-> (res_lv < halt_lv));
  p_auto_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |-> !rts_n);
  p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full) && cnt <= LW'(DEPTH));

endmodule

// File: tb/test_rx_fifo_autorts.sv
module test_rx_fifo_autorts;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, ovf_clr = 0, rts_auto_en = 1;
  logic [7:0] wr_data = 0, trig_cfg = 8'h8F;
  logic [7:0] rd_data;
  logic [6:0] level;
  logic empty, full, ovf, rts_n;

  rx_fifo_autorts i_rx_fifo_autorts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .trig_cfg(trig_cfg),
    .rts_auto_en(rts_auto_en), .ovf_clr(ovf_clr), .level(level),
    .empty(empty), .full(full), .ovf(ovf), .rts_n(rts_n));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] q [64];
  int qh = 0, qt = 0, mc = 0;
  logic m_halt = 0, m_ovf = 0;
  int H = 60, Rf = 32;
  logic [7:0] seq = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] c);
    int rr;
    trig_cfg = c;
    H = int'(c[3:0]) * 4;
    rr = int'(c[7:4]) * 4;
    Rf = (rr < H) ? rr : ((H >= 4) ? H - 4 : 0);
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] d);
    bit ar, aw;
    @(negedge clk); wr_en = w; rd_en = r; wr_data = d;
    @(negedge clk); wr_en = 0; rd_en = 0;
    @(negedge clk);
    ar = r && mc > 0;
    aw = w && (mc < 64 || ar);
    if (ar) begin qh = (qh + 1) % 64; mc--; end
    if (aw) begin q[qt] = d; qt = (qt + 1) % 64; mc++; end
    if (w && !aw) m_ovf = 1;
    if (mc >= H) m_halt = 1;
    else if (mc <= Rf) m_halt = 0;
  endtask

  task automatic check_state(input string req);
    chk({req, " level"}, int'(level), mc);
    chk({req, " rts_n"}, int'(rts_n), int'(m_halt && rts_auto_en));
    chk("R11 empty", int'(empty), int'(mc == 0));
    chk("R11 full", int'(full), int'(mc == 64));
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_cfg(8'h8F);
    repeat (3) @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    rst_n = 1;

    // R5 R6 R7 R8 R9: full sweep of threshold pairs
    for (int h = 0; h < 16; h++) begin
      for (int r = 0; r < 16; r++) begin
        set_cfg({r[3:0], h[3:0]});
        step(0, 0, 0);
        check_state("R8 cfg");
        while (mc < H) begin
          step(1, 0, seq); seq++;
          check_state("R6 fill");
        end
        step(1, 0, seq); seq++;
        check_state("R9 extra");
        chk("R9 no drop", int'(ovf), 0);
        while (mc > 0) begin
          chk("R2 order", int'(rd_data), int'(q[qh]));
          step(0, 1, 0);
          check_state("R7 drain");
        end
      end
    end

    // R2: read while empty ignored
    step(0, 1, 0);
    check_state("R2 empty read");

    // R3 R4 R11: full buffer behaviour
    set_cfg(8'h8F);
    step(0, 0, 0);
    for (int i = 0; i < 64; i++) begin step(1, 0, 8'(i + 100)); end
    check_state("R11 filled");
    chk("R3 ovf before", int'(ovf), 0);
    step(1, 1, 8'hAA);
    check_state("R4 full pair");
    chk("R4 no ovf", int'(ovf), 0);
    step(1, 0, 8'hBB);
    check_state("R3 drop");
    chk("R3 ovf set", int'(ovf), 1);
    step(0, 0, 0);
    chk("R3 ovf sticky", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk);
    chk("R3 ovf cleared", int'(ovf), 0);

    // R10: auto disabled holds request asserted while halted
    chk("R10 halted", int'(rts_n), 1);
    rts_auto_en = 0;
    @(negedge clk);
    chk("R10 forced", int'(rts_n), 0);
    rts_auto_en = 1;
    @(negedge clk);

    // R2 R4: drain with data check, paired access mid-fill
    while (mc > 10) begin
      chk("R2 order", int'(rd_data), int'(q[qh]));
      step(0, 1, 0);
      check_state("R7 drain2");
    end
    step(1, 1, 8'h55);
    check_state("R4 mid pair");
    while (mc > 0) begin
      chk("R2 order", int'(rd_data), int'(q[qh]));
      step(0, 1, 0);
    end
    check_state("R2 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule